// File: doc/BRIEF.md
# Row-Preserving Switch Allocator with Hold Grant

This block is the switch allocator of an on-chip router. The router carries memory requests from many compute cores toward DRAM controllers. Each input port presents a vector that says which outputs it wants, together with the DRAM row tag of the request at its head. Every cycle the allocator returns a registered one-hot grant matrix. Each input receives at most one output and each output serves at most one input.

Allocation is separable and runs in two stages. A round-robin arbiter at each input picks one of the outputs that input requests. A round-robin arbiter at each output then picks among the inputs that chose it. A mode input can put a hold ahead of this arbitration, so that a pair granted in the last cycle wins again. The hold applies either whenever the pair is still requested, or only when the new row tag equals the row tag of the winning request. Streams of packets aimed at one DRAM row then stay together as they cross the network, which lets simple in-order memory controllers keep a high row-hit rate.

A small combinational helper gives the static virtual channel for a source core and destination controller. Every router then assigns the same channel to the same traffic pair.

Top module: `hg_switch_alloc`

## Requirements
- R1: Allocation is separable. Input i considers only outputs it requests (request bit i*NUM_PORTS+o of req_i) and picks one by round robin starting at its pointer. Output o then picks by round robin among the inputs whose pick was o. After reset all pointers are 0, so with every request set the first grant is input 0 to output 0 only.
- R2: In every cycle gnt_o holds at most one set bit per input and at most one per output. Grant bit i*NUM_PORTS+o means input i owns output o.
- R3: gnt_o is registered. It shows the allocation of the inputs sampled at the previous rising edge, and it is all zeros after reset.
- R4: mode_i encoding: 0 is plain round robin, 1 is hold grant, 2 is row-matching hold grant, and 3 behaves exactly as 0.
- R5: In mode 1, a pair granted in the previous cycle that is still requested is granted again, whatever its row tag and whatever other inputs request.
- R6: In mode 2, a pair granted in the previous cycle and still requested is granted again only if the input's current row tag equals the row tag it had when last granted. Otherwise normal two-stage arbitration decides.
- R7: A pointer moves to one past its winner only when that arbiter's choice becomes a fresh, non-held grant. With all inputs requesting only output 0 in mode 0, the grants rotate 0,1,2,3,4,0.
- R8: The input and output of a held pair take no part in the fresh arbitration of that cycle. Other inputs can still win other free outputs in the same cycle.
- R9: vc_o equals (src_id_i XOR dst_id_i) modulo NUM_VC, computed combinationally.
- R10: A hold ends as soon as its input stops requesting the output. That output then goes through normal arbitration in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Allocation mode (0 round robin, 1 hold, 2 row-matching hold, 3 as 0) |
| req_i | input | NUM_PORTS*NUM_PORTS | Request matrix, bit i*NUM_PORTS+o: input i wants output o |
| row_i | input | NUM_PORTS*ROW_W | Row tag per input, input i at bits i*ROW_W upward |
| src_id_i | input | SRC_W | Source core of the request being classified |
| dst_id_i | input | DST_W | Destination controller of the request being classified |
| gnt_o | output | NUM_PORTS*NUM_PORTS | Registered grant matrix, same layout as req_i |
| vc_o | output | VC_W | Static virtual channel for the source and destination pair |

## Verification
The bench targets a held pair that competes with a higher-priority requester. A design that let round robin override the hold would hand the output to the other input and split the row stream. In row-matching mode it changes the row tag under a standing request. A design that ignored the tag would keep the stale hold, and one that compared against the wrong captured tag would drop a matching hold. It also checks that mode 3 acts as plain round robin, that a free output beside a held pair is still granted in the same cycle, and that a released hold goes back to arbitration at once. A wrong pointer rule would break the round-robin rotation, and a misrouted grant would show up as a conflict in the per-cycle matrix check.

// File: rtl/hg_alloc_pkg.sv
package hg_alloc_pkg;
  typedef enum logic [1:0] {
    MODE_RR   = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_ROW  = 2'd2,
    MODE_RSVD = 2'd3
  } alloc_mode_e;
endpackage

// File: rtl/hg_rr_arb.sv
module hg_rr_arb #(
  parameter int N = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             upd_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int c;
    logic found;
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (!found && req_i[c]) begin
        found = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o = IDX_W'(c);
      end
    end
  end

  // pointer moves past the winner only on a fresh grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (upd_i) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + IDX_W'(1);
  end

  a_r1_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> $onehot(gnt_o));
  a_r1_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/hg_static_vc.sv
module hg_static_vc #(
  parameter int SRC_W  = 6,
  parameter int DST_W  = 3,
  parameter int NUM_VC = 4,
  localparam int ID_W  = (SRC_W > DST_W) ? SRC_W : DST_W,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [DST_W-1:0] dst_i,
  output logic [VC_W-1:0]  vc_o
);
  logic [ID_W-1:0] mix;
  logic [31:0]     mix_w;

  always_comb begin
    mix   = ID_W'(src_i) ^ ID_W'(dst_i);
    mix_w = 32'(mix);
    vc_o  = VC_W'(mix_w % 32'(NUM_VC));
  end
endmodule

// File: rtl/hg_switch_alloc.sv
module hg_switch_alloc
  import hg_alloc_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ROW_W     = 14,
  parameter int SRC_W     = 6,
  parameter int DST_W     = 3,
  parameter int NUM_VC    = 4,
  localparam int P        = NUM_PORTS,
  localparam int IDX_W    = (P > 1) ? $clog2(P) : 1,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [P*P-1:0]     req_i,
  input  logic [P*ROW_W-1:0] row_i,
  input  logic [SRC_W-1:0]   src_id_i,
  input  logic [DST_W-1:0]   dst_id_i,
  output logic [P*P-1:0]     gnt_o,
  output logic [VC_W-1:0]    vc_o
);
  alloc_mode_e mode;
  logic [P-1:0]     req_m  [P];   // [input][output]
  logic [ROW_W-1:0] row_m  [P];
  logic [P-1:0]     gnt_q  [P];   // [input][output]
  logic [ROW_W-1:0] row_q  [P];
  logic [P-1:0]     hold   [P];   // [input][output]
  logic [P-1:0]     s1_req [P];   // [input][output]
  logic [P-1:0]     s1_gnt [P];   // [input][output]
  logic [IDX_W-1:0] s1_idx [P];
  logic [P-1:0]     s2_req [P];   // [output][input]
  logic [P-1:0]     s2_gnt [P];   // [output][input]
  logic [IDX_W-1:0] s2_idx [P];
  logic [P-1:0]     fresh  [P];   // [input][output]
  logic [P-1:0]     held_in, held_out, in_upd, out_upd;
  logic             hold_en;

  assign mode    = alloc_mode_e'(mode_i);
  assign hold_en = (mode == MODE_HOLD) || (mode == MODE_ROW);

  for (genvar i = 0; i < P; i++) begin : g_unpack
    assign req_m[i] = req_i[i*P +: P];
    assign row_m[i] = row_i[i*ROW_W +: ROW_W];
    assign gnt_o[i*P +: P] = gnt_q[i];
  end

  // hold detection: previous winner still asking, optional row match
  always_comb begin
    held_out = '0;
    for (int i = 0; i < P; i++) begin
      for (int o = 0; o < P; o++) begin
        hold[i][o] = gnt_q[i][o] && req_m[i][o] && hold_en &&
                     ((mode != MODE_ROW) || (row_m[i] == row_q[i]));
      end
      held_in[i] = |hold[i];
      held_out   = held_out | hold[i];
    end
  end

  // stage 1: per-input arbitration over free outputs
  for (genvar i = 0; i < P; i++) begin : g_in
    assign s1_req[i] = held_in[i] ? '0 : (req_m[i] & ~held_out);
    hg_rr_arb #(.N(P)) u_in_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (s1_req[i]),
      .upd_i (in_upd[i]),
      .gnt_o (s1_gnt[i]),
      .idx_o (s1_idx[i])
    );
  end

  // stage 2: per-output arbitration over stage-1 winners
  for (genvar o = 0; o < P; o++) begin : g_out
    for (genvar i = 0; i < P; i++) begin : g_col
      assign s2_req[o][i] = s1_gnt[i][o];
      assign fresh[i][o]  = s2_gnt[o][i];
    end
    hg_rr_arb #(.N(P)) u_out_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (s2_req[o]),
      .upd_i (out_upd[o]),
      .gnt_o (s2_gnt[o]),
      .idx_o (s2_idx[o])
    );
    assign out_upd[o] = |s2_gnt[o];
  end

  for (genvar i = 0; i < P; i++) begin : g_iupd
    assign in_upd[i] = |fresh[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < P; i++) begin
        gnt_q[i] <= '0;
        row_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < P; i++) begin
        gnt_q[i] <= hold[i] | fresh[i];
        if (|(hold[i] | fresh[i])) row_q[i] <= row_m[i];
      end
    end
  end

  hg_static_vc #(.SRC_W(SRC_W), .DST_W(DST_W), .NUM_VC(NUM_VC)) u_vc (
    .src_i(src_id_i),
    .dst_i(dst_id_i),
    .vc_o (vc_o)
  );

  for (genvar i = 0; i < P; i++) begin : g_chk
    logic [P-1:0] col;
    for (genvar k = 0; k < P; k++) begin : g_c
      assign col[k] = gnt_q[k][i];
    end
    a_r2_input_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_q[i]));
    a_r2_output_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
    for (genvar o = 0; o < P; o++) begin : g_pair
      a_r5_hold_regrant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd1 && gnt_q[i][o] && req_m[i][o]) |=> gnt_q[i][o]);
      a_r6_row_regrant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd2 && gnt_q[i][o] && req_m[i][o] && row_m[i] == row_q[i])
        |=> gnt_q[i][o]);
      a_r10_no_req_no_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_m[i][o] |=> !gnt_q[i][o]);
    end
  end
endmodule

// File: tb/hg_switch_alloc_bench.sv
`timescale 1ns/1ps
module hg_switch_alloc_bench;
  localparam int P      = 5;
  localparam int ROW_W  = 14;
  localparam int SRC_W  = 6;
  localparam int DST_W  = 3;
  localparam int NUM_VC = 4;
  localparam int VC_W   = 2;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [1:0]         mode = '0;
  logic [P*P-1:0]     req = '0;
  logic [P*ROW_W-1:0] row = '0;
  logic [SRC_W-1:0]   src = '0;
  logic [DST_W-1:0]   dst = '0;
  logic [P*P-1:0]     gnt;
  logic [VC_W-1:0]    vc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [P*P-1:0]   m_gnt;
  logic [ROW_W-1:0] m_row [P];
  int               m_iptr [P];
  int               m_optr [P];

  always #2 clk = ~clk;

  hg_switch_alloc #(.NUM_PORTS(P), .ROW_W(ROW_W), .SRC_W(SRC_W), .DST_W(DST_W),
                    .NUM_VC(NUM_VC)) u_hg_switch_alloc (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .req_i(req), .row_i(row),
    .src_id_i(src), .dst_id_i(dst), .gnt_o(gnt), .vc_o(vc)
  );

  function automatic int bi(int i, int o);
    return i * P + o;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rr_pick(logic [P-1:0] r, int ptr);
    for (int k = 0; k < P; k++) begin
      if (r[(ptr + k) % P]) return (ptr + k) % P;
    end
    return -1;
  endfunction

  task automatic model_reset();
    m_gnt = '0;
    for (int i = 0; i < P; i++) begin
      m_row[i] = '0; m_iptr[i] = 0; m_optr[i] = 0;
    end
  endtask

  task automatic model_step();
    logic [P*P-1:0] hold, nxt;
    logic [P-1:0] hin, hout, r;
    int pick [P];
    logic [P-1:0] cand;
    int w;
    hold = '0; hin = '0; hout = '0; nxt = '0;
    for (int i = 0; i < P; i++)
      for (int o = 0; o < P; o++)
        if (m_gnt[bi(i,o)] && req[bi(i,o)] &&
            (mode == 2'd1 || (mode == 2'd2 && row[i*ROW_W +: ROW_W] == m_row[i]))) begin
          hold[bi(i,o)] = 1'b1; hin[i] = 1'b1; hout[o] = 1'b1;
        end
    for (int i = 0; i < P; i++) begin
      r = req[i*P +: P] & ~hout;
      pick[i] = hin[i] ? -1 : rr_pick(r, m_iptr[i]);
    end
    for (int o = 0; o < P; o++) begin
      cand = '0;
      for (int i = 0; i < P; i++) cand[i] = (pick[i] == o);
      w = rr_pick(cand, m_optr[o]);
      if (w >= 0) begin
        nxt[bi(w,o)] = 1'b1;
        m_optr[o] = (w + 1) % P;
        m_iptr[w] = (o + 1) % P;
      end
    end
    nxt = nxt | hold;
    for (int i = 0; i < P; i++)
      if (|nxt[i*P +: P]) m_row[i] = row[i*ROW_W +: ROW_W];
    m_gnt = nxt;
  endtask

  function automatic bit conflict_free(logic [P*P-1:0] g);
    int ci, co;
    for (int a = 0; a < P; a++) begin
      ci = 0; co = 0;
      for (int b = 0; b < P; b++) begin
        ci += int'(g[bi(a,b)]);
        co += int'(g[bi(b,a)]);
      end
      if (ci > 1 || co > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic step(input logic [1:0] m, input logic [P*P-1:0] rq,
                      input logic [P*ROW_W-1:0] rw);
    string tag;
    @(negedge clk);
    mode = m; req = rq; row = rw;
    model_step();
    @(posedge clk);
    #1;
    case (m)
      2'd0: tag = "R1 rr";
      2'd1: tag = "R5 hold";
      2'd2: tag = "R6 rowhold";
      default: tag = "R4 mode3";
    endcase
    check(gnt === m_gnt, tag, 64'(gnt), 64'(m_gnt));
    check(conflict_free(gnt), "R2 conflict", 64'(gnt), 64'(m_gnt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req = '0; mode = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  function automatic logic [P*ROW_W-1:0] row_set(int i, int v);
    logic [P*ROW_W-1:0] r;
    r = '0;
    r[i*ROW_W +: ROW_W] = ROW_W'(v);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [P*P-1:0] rq;
    logic [P*ROW_W-1:0] rw;
    model_reset();
    do_reset();
    #1;
    check(gnt == '0, "R3 reset", 64'(gnt), 64'(0));

    // R3: grant appears only after the edge
    @(negedge clk);
    req = '0; req[bi(1,2)] = 1'b1;
    #1;
    check(gnt == '0, "R3 before edge", 64'(gnt), 64'(0));
    do_reset();

    // R1: full request matrix after reset
    step(2'd0, '1, '0);
    check(gnt == (64'(1) << bi(0,0)), "R1 first", 64'(gnt), 64'(1));
    step(2'd0, '1, '0);
    check(gnt == ((64'(1) << bi(1,0)) | (64'(1) << bi(0,1))), "R1 second",
          64'(gnt), 64'h22);

    // R7: rotation on output 0
    do_reset();
    rq = '0;
    for (int i = 0; i < P; i++) rq[bi(i,0)] = 1'b1;
    for (int k = 0; k <= P; k++) begin
      step(2'd0, rq, '0);
      check(gnt == (64'(1) << bi(k % P, 0)), "R7 rotate", 64'(gnt),
            64'(1) << bi(k % P, 0));
    end

    // R5, R8, R10: hold mode
    do_reset();
    rq = '0; rq[bi(2,3)] = 1'b1;
    step(2'd1, rq, row_set(2, 7));
    check(gnt == (64'(1) << bi(2,3)), "R5 setup", 64'(gnt), 64'(1) << bi(2,3));
    rq[bi(0,3)] = 1'b1; rq[bi(1,3)] = 1'b1; rq[bi(1,1)] = 1'b1;
    step(2'd1, rq, row_set(2, 9));
    check(gnt[bi(2,3)] == 1'b1, "R5 held", 64'(gnt), 64'(1) << bi(2,3));
    check(gnt == ((64'(1) << bi(2,3)) | (64'(1) << bi(1,1))), "R8 side grant",
          64'(gnt), (64'(1) << bi(2,3)) | (64'(1) << bi(1,1)));
    rq[bi(2,3)] = 1'b0;
    step(2'd1, rq, row_set(2, 9));
    check(gnt == ((64'(1) << bi(1,1)) | (64'(1) << bi(0,3))), "R10 release",
          64'(gnt), (64'(1) << bi(1,1)) | (64'(1) << bi(0,3)));

    // R6: row-matching hold
    do_reset();
    rq = '0; rq[bi(2,3)] = 1'b1;
    step(2'd2, rq, row_set(2, 7));
    rq[bi(0,3)] = 1'b1;
    step(2'd2, rq, row_set(2, 7));
    check(gnt == (64'(1) << bi(2,3)), "R6 match holds", 64'(gnt), 64'(1) << bi(2,3));
    step(2'd2, rq, row_set(2, 9));
    check(gnt == (64'(1) << bi(0,3)), "R6 mismatch rearb", 64'(gnt), 64'(1) << bi(0,3));

    // R4: mode 3 never holds
    do_reset();
    rq = '0; rq[bi(2,3)] = 1'b1;
    step(2'd3, rq, '0);
    rq[bi(0,3)] = 1'b1;
    step(2'd3, rq, '0);
    check(gnt == (64'(1) << bi(0,3)), "R4 mode3 plain", 64'(gnt), 64'(1) << bi(0,3));

    // sweep all modes with sparse requests and few row tags
    for (int m = 0; m < 4; m++) begin
      do_reset();
      for (int c = 0; c < 600; c++) begin
        rq = P*P'($urandom) & P*P'($urandom);
        if (c % 3 != 0) rq = rq | (gnt & P*P'($urandom));
        rw = '0;
        for (int i = 0; i < P; i++) rw[i*ROW_W +: ROW_W] = ROW_W'($urandom_range(0, 2));
        step(2'(m), rq, rw);
      end
    end

    // R9: exhaustive virtual-channel map
    for (int s = 0; s < (1 << SRC_W); s++) begin
      for (int d = 0; d < (1 << DST_W); d++) begin
        src = SRC_W'(s); dst = DST_W'(d);
        #1;
        check(int'(vc) == ((s ^ d) % NUM_VC), "R9 vc", 64'(vc), 64'((s ^ d) % NUM_VC));
      end
    end

    finish_run();
  end
endmodule